// File: doc/BRIEF.md
# Codec Access Semaphore and PCM Sample Port

This block is a small register slice of an audio-codec link controller. Its first register is a one-bit lock for the codec command channel. A driver reads the lock. If the read returns zero, that same read has taken the lock for the driver. If it returns one, some other driver holds the channel and must retry later. The lock is released in one of two ways: the link engine pulses a completion input when the codec IO cycle ends, or software writes zero to the bit because it decided not to issue a cycle.

The second register is a stereo sample port. A bus write pushes one 32-bit word into a transmit FIFO, and the link engine drains that FIFO. A bus read pops one word from a receive FIFO, which the link engine fills. Each word holds the right-channel sample in the upper half and the left-channel sample in the lower half. Both FIFOs are inside the block. Overrun on the transmit side and underrun on the receive side are recorded in sticky flags.

Top module: `codec_port_regs`

## Requirements
- R1: After reset, bus_rdata is 0, the lock bit is 0, both FIFOs are empty (levels 0, tx_empty 1), and both sticky flags are 0.
- R2: A read of byte offset 0x20 that finds the lock bit clear returns 0 in bit 0, and the bit is 1 after that read.
- R3: A read of offset 0x20 that finds the lock bit set returns 1 and leaves the bit set.
- R4: A cyc_done pulse clears the lock bit. When cyc_done arrives in the same cycle as an acquiring read, the read returns 0 and the bit is clear afterwards.
- R5: A write to offset 0x20 with bit 0 equal to 0 clears the lock. A write with bit 0 equal to 1 has no effect. Bits 31:1 of offset 0x20 always read as 0.
- R6: A write to offset 0x40 pushes the 32-bit word into the transmit FIFO, with the right sample in bits 31:16 and the left sample in bits 15:0. The link engine sees the words on tx_data in write order.
- R7: A read of offset 0x40 returns the oldest receive FIFO word on bus_rdata one clock after the read strobe.
- R8: Each FIFO holds 16 words. A write to 0x40 when the transmit FIFO is full is dropped and sets tx_overrun, which stays set until reset.
- R9: A read of 0x40 when the receive FIFO is empty returns 0 and sets rx_underrun, which stays set until reset.
- R10: Reads of any other offset return 0. Writes to any other offset change neither register.
- R11: Each one-cycle read strobe of 0x40 pops exactly one receive word. Each one-cycle write strobe pushes exactly one transmit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset within the block |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| cyc_done | input | 1 | Link engine pulse: codec IO cycle finished |
| tx_pop | input | 1 | Link engine takes the head word of the transmit FIFO |
| tx_data | output | 32 | Head word of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO is empty |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_push | input | 1 | Link engine stores rx_data into the receive FIFO |
| rx_data | input | 32 | Word delivered by the link engine |
| rx_full | output | 1 | Receive FIFO is full |
| rx_level | output | 5 | Receive FIFO occupancy |
| tx_overrun | output | 1 | Sticky: a bus write was lost to a full transmit FIFO |
| rx_underrun | output | 1 | Sticky: a bus read found the receive FIFO empty |

## Verification
The bench first targets the lock. It checks that a second reader sees the lock busy. A design that sets the bit on every read, or that clears it on a busy read, would grant the channel twice. It also drives a completion pulse in the same cycle as an acquiring read. A design with the wrong priority would leave the lock held with no owner. Both FIFOs are swept through all 16 slots and one entry past that, with words built arithmetically from the slot index. This catches an off-by-one depth, an overwrite of the oldest word, a swapped channel half, and a double pop caused by a strobe that is decoded more than once. Writes of 1 to the lock and accesses to unmapped offsets are checked at the ports by reading back the lock state and the FIFO levels.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = WORD_W / 2;

  // Next state of the lock bit. Order of precedence: hardware release,
  // then software release, then acquisition by a read that finds it clear.
  function automatic logic lock_next(input logic cur, input logic acq_rd,
                                     input logic sw_rel, input logic hw_rel);
    logic n;
    n = cur;
    if (acq_rd && !cur) n = 1'b1;
    if (sw_rel)         n = 1'b0;
    if (hw_rel)         n = 1'b0;
    return n;
  endfunction

  // Stereo word layout: right channel high, left channel low.
  function automatic logic [WORD_W-1:0] pack_stereo(input logic [HALF_W-1:0] right,
                                                    input logic [HALF_W-1:0] left);
    return {right, left};
  endfunction

endpackage

// File: rtl/codec_port_fifo.sv
module codec_port_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);

  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LVL_FULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/codec_port_lock.sv
module codec_port_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_rd,
  input  logic sw_rel,
  input  logic hw_rel,
  output logic held
);
  import codec_port_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) held <= 1'b0;
    else        held <= lock_next(held, acq_rd, sw_rel, hw_rel);
  end

endmodule

// File: rtl/codec_port_regs.sv
module codec_port_regs #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter logic [ADDR_W-1:0] LOCK_OFS = ADDR_W'(8'h20),
  parameter logic [ADDR_W-1:0] PCM_OFS  = ADDR_W'(8'h40),
  localparam int unsigned DW = codec_port_pkg::WORD_W,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              cyc_done,
  input  logic              tx_pop,
  output logic [DW-1:0]     tx_data,
  output logic              tx_empty,
  output logic [CW-1:0]     tx_level,
  input  logic              rx_push,
  input  logic [DW-1:0]     rx_data,
  output logic              rx_full,
  output logic [CW-1:0]     rx_level,
  output logic              tx_overrun,
  output logic              rx_underrun
);

  // Named decode events, also observed by the bound checker.
  logic sel_lock, sel_pcm;
  logic rd_lock, wr_lock, rd_pcm, wr_pcm;
  logic lock_rel_sw, lock_q;
  logic tx_full, rx_empty;
  logic ovr_evt, und_evt;
  logic [DW-1:0] rx_head;

  assign sel_lock    = (bus_addr == LOCK_OFS);
  assign sel_pcm     = (bus_addr == PCM_OFS);
  assign rd_lock     = bus_rd && sel_lock;
  assign wr_lock     = bus_wr && sel_lock;
  assign rd_pcm      = bus_rd && sel_pcm;
  assign wr_pcm      = bus_wr && sel_pcm;
  assign lock_rel_sw = wr_lock && !bus_wdata[0];
  assign ovr_evt     = wr_pcm && tx_full;
  assign und_evt     = rd_pcm && rx_empty;

  codec_port_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .acq_rd (rd_lock),
    .sw_rel (lock_rel_sw),
    .hw_rel (cyc_done),
    .held   (lock_q)
  );

  codec_port_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_pcm),
    .din   (bus_wdata),
    .pop   (tx_pop),
    .head  (tx_data),
    .empty (tx_empty),
    .full  (tx_full),
    .level (tx_level)
  );

  codec_port_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (rd_pcm),
    .head  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .level (rx_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      tx_overrun  <= 1'b0;
      rx_underrun <= 1'b0;
    end else begin
      if (ovr_evt) tx_overrun  <= 1'b1;
      if (und_evt) rx_underrun <= 1'b1;
      if (bus_rd) begin
        if (sel_lock)     bus_rdata <= {{(DW-1){1'b0}}, lock_q};
        else if (sel_pcm) bus_rdata <= rx_empty ? '0 : rx_head;
        else              bus_rdata <= '0;
      end
    end
  end

endmodule

// File: rtl/codec_port_chk.sv
module codec_port_chk #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 32,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_lock,
  input logic          wr_lock,
  input logic          rd_pcm,
  input logic          lock_rel_sw,
  input logic          lock_q,
  input logic          cyc_done,
  input logic          bus_wdata0,
  input logic          bus_rd,
  input logic          sel_lock,
  input logic          sel_pcm,
  input logic          rx_empty,
  input logic [DW-1:0] bus_rdata,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level,
  input logic          tx_overrun,
  input logic          rx_underrun
);

  a_r2_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && !lock_q && !cyc_done && !lock_rel_sw) |=> lock_q);

  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lock && lock_q && !cyc_done && !lock_rel_sw) |=> (lock_q && bus_rdata == DW'(1)));

  a_r4_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !lock_q);

  a_r5_set_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && bus_wdata0 && !lock_q && !rd_lock) |=> !lock_q);

  a_r8_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> tx_overrun);

  a_r9_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pcm && rx_empty) |=> (bus_rdata == '0 && rx_underrun));

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun |=> rx_underrun);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !sel_lock && !sel_pcm) |=> (bus_rdata == '0));

endmodule

bind codec_port_regs codec_port_chk #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_lock     (rd_lock),
  .wr_lock     (wr_lock),
  .rd_pcm      (rd_pcm),
  .lock_rel_sw (lock_rel_sw),
  .lock_q      (lock_q),
  .cyc_done    (cyc_done),
  .bus_wdata0  (bus_wdata[0]),
  .bus_rd      (bus_rd),
  .sel_lock    (sel_lock),
  .sel_pcm     (sel_pcm),
  .rx_empty    (rx_empty),
  .bus_rdata   (bus_rdata),
  .tx_level    (tx_level),
  .rx_level    (rx_level),
  .tx_overrun  (tx_overrun),
  .rx_underrun (rx_underrun)
);

// File: tb/codec_port_regs_bench.sv
module codec_port_regs_bench;

  localparam int unsigned DEPTH = 16;
  localparam logic [7:0] A_LOCK = 8'h20;
  localparam logic [7:0] A_PCM  = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cyc_done = 1'b0;
  logic        tx_pop = 1'b0;
  logic [31:0] tx_data;
  logic        tx_empty;
  logic [4:0]  tx_level;
  logic        rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic        rx_full;
  logic [4:0]  rx_level;
  logic        tx_overrun, rx_underrun;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  codec_port_regs u_codec_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cyc_done(cyc_done),
    .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty), .tx_level(tx_level),
    .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full), .rx_level(rx_level),
    .tx_overrun(tx_overrun), .rx_underrun(rx_underrun)
  );

  // Bench's own word builder: right sample * 65536 + left sample.
  function automatic logic [31:0] stereo(input int r, input int l);
    return 32'((r & 16'hFFFF) * 65536 + (l & 16'hFFFF));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); cyc_done = 1'b1;
    @(negedge clk); cyc_done = 1'b0;
  endtask

  task automatic link_push(input logic [31:0] d);
    @(negedge clk); rx_data = d; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic link_pop();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 tx_empty", {31'b0, tx_empty}, 32'h1);
    chk("R1 levels", {22'b0, tx_level, rx_level}, 32'h0);
    chk("R1 flags", {30'b0, tx_overrun, rx_underrun}, 32'h0);

    // R2 / R3 acquire, then busy
    rd(A_LOCK, d); chk("R2 first read clear", d, 32'h0);
    rd(A_LOCK, d); chk("R3 second read busy", d, 32'h1);
    rd(A_LOCK, d); chk("R3 bit kept set", d, 32'h1);

    // R4 hardware release
    done_pulse();
    rd(A_LOCK, d); chk("R4 released by done", d, 32'h0);
    // lock now held again; release by software (R5)
    wr(A_LOCK, 32'hFFFF_FFFE);
    rd(A_LOCK, d); chk("R5 sw clear", d, 32'h0);
    // now held; release then write 1
    done_pulse();
    wr(A_LOCK, 32'hFFFF_FFFF);
    rd(A_LOCK, d); chk("R5 write one ignored, upper bits zero", d, 32'h0);
    rd(A_LOCK, d); chk("R5 upper bits read zero", d, 32'h1);

    // R4 collision: done and acquiring read in the same cycle
    done_pulse();
    @(negedge clk); bus_addr = A_LOCK; bus_rd = 1'b1; cyc_done = 1'b1;
    @(negedge clk); bus_rd = 1'b0; cyc_done = 1'b0;
    chk("R4 collision read value", bus_rdata, 32'h0);
    rd(A_LOCK, d); chk("R4 collision leaves clear", d, 32'h0);
    done_pulse();

    // R10 unmapped offsets
    wr(8'h24, 32'h0);
    wr(8'h44, 32'h1234_5678);
    chk("R10 write elsewhere no push", {27'b0, tx_level}, 32'h0);
    rd(8'h00, d); chk("R10 read 0x00", d, 32'h0);
    rd(8'h60, d); chk("R10 read 0x60", d, 32'h0);
    rd(A_LOCK, d); chk("R10 lock untouched", d, 32'h0);
    done_pulse();

    // R6 / R8 / R11 transmit sweep
    for (int i = 0; i < DEPTH; i++) begin
      wr(A_PCM, stereo(16'hA000 + i, 16'h0100 + 3 * i));
      chk("R11 one push per write", {27'b0, tx_level}, 32'(i + 1));
    end
    chk("R8 no overrun at full", {31'b0, tx_overrun}, 32'h0);
    wr(A_PCM, 32'hDEAD_BEEF);
    chk("R8 overrun set", {31'b0, tx_overrun}, 32'h1);
    chk("R8 level stays full", {27'b0, tx_level}, 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      chk("R6 tx order and halves", tx_data, stereo(16'hA000 + i, 16'h0100 + 3 * i));
      link_pop();
    end
    chk("R6 drained", {31'b0, tx_empty}, 32'h1);
    chk("R8 overrun sticky", {31'b0, tx_overrun}, 32'h1);

    // R9 empty read
    rd(A_PCM, d); chk("R9 empty read zero", d, 32'h0);
    chk("R9 underrun set", {31'b0, rx_underrun}, 32'h1);

    // R7 / R8 / R11 receive sweep
    for (int i = 0; i <= DEPTH; i++) link_push(stereo(7 * i, 16'hF000 - i));
    chk("R8 rx depth", {27'b0, rx_level}, 32'(DEPTH));
    chk("R8 rx full", {31'b0, rx_full}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_PCM, d);
      chk("R7 rx word in order", d, stereo(7 * i, 16'hF000 - i));
      chk("R11 one pop per read", {27'b0, rx_level}, 32'(DEPTH - 1 - i));
    end
    rd(A_PCM, d); chk("R9 empty again", d, 32'h0);
    chk("R9 underrun sticky", {31'b0, rx_underrun}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule